// File: doc/BRIEF.md
# Timer Count-Enable Generator

This block turns one of four event sources into a single-cycle count-enable tick for a modulo timer counter. All of its logic runs on the system bus clock. A byte-wide control register holds a 2-bit source select and a 4-bit division select. The parent timer writes that register and reads it back.

The selected source can be one of four things. The first is the bus clock itself, which gives an event every cycle. The second is a slower fixed-frequency clock that arrives as a one-cycle strobe. The third and fourth are an external timer pin, after a two-flop synchronizer, counted on its falling edge or on its rising edge. Each source event advances an 8-bit free-running prescaler. A tap chosen by the division select decides which events become a tick, giving a division by any power of two from 1 to 256.

A write to the control register while counting does not disturb the prescaler. A halt input lets the parent timer clear the prescaler when it resets its own counter.

Top module: `tmr_cnt_enable`

## Requirements
- R1: After a synchronous reset the control register reads 0x00. This selects the bus clock with division by 1, so `tick` is high in every cycle once `halt` is low.
- R2: A write loads `wr_data[5:4]` into the source field and `wr_data[3:0]` into the division field. From the next cycle `rd_data` returns `{2'b00, source, division}`, and bits 7:6 read 0 whatever was written to them.
- R3: Source code 00 (bus clock) makes every cycle a source event.
- R4: Source code 01 (fixed clock) makes a source event exactly in the cycles where `fixed_stb` is high.
- R5: Source code 10 counts falling edges of `ext_pin`. Suppose `ext_pin` changes before clock edge k, and no edge of the clock separates the change from edge k. Then the event is high in the cycle between edges k+1 and k+2, and in no other cycle. A rising edge produces no event.
- R6: Source code 11 counts rising edges of `ext_pin` with the same latency as R5. A falling edge produces no event.
- R7: For a division code n from 0 to 8, counted from a cleared prescaler, `tick` is high on source events number 2^n, 2·2^n, 3·2^n and so on. `tick` is never high in a cycle without a source event.
- R8: Division codes 9 through 15 behave exactly like code 8, which is division by 256.
- R9: Writing a new source or division code while counting keeps the prescaler value. Ticks continue from the old count under the new setting.
- R10: While `halt` is high, `tick` is low and the prescaler is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| fixed_stb | input | 1 | One-cycle strobe of the fixed-frequency clock |
| ext_pin | input | 1 | Asynchronous external timer pin |
| halt | input | 1 | Holds the prescaler cleared and suppresses ticks |
| tick | output | 1 | Count-enable tick to the timer counter |

## Verification
`tick` is combinational from the current source event and the prescaler state. For the bus and strobe sources, a tick is due in the same cycle as the event. For a pin edge, a tick is due in the second cycle after the first clock edge that samples the change. A register write shows on `rd_data` and takes effect one cycle after the write edge. The bench drives inputs on the falling clock edge and samples 1 ns later, so every cycle shows the state settled after the preceding rising edge. Each expectation is computed from these latencies, counting events from a prescaler cleared by `halt`.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

    localparam int PS_W   = 8;
    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        SRC_BUS      = 2'b00,
        SRC_FIXED    = 2'b01,
        SRC_PIN_FALL = 2'b10,
        SRC_PIN_RISE = 2'b11
    } src_e;

    typedef struct packed {
        src_e              src;
        logic [CODE_W-1:0] div;
    } ctrl_t;

    // Low-bit mask of the prescaler that must be all ones for a tick.
    function automatic logic [PS_W-1:0] tap_mask(input logic [CODE_W-1:0] code);
        logic [PS_W:0] full;
        int            n;
        n    = (int'(code) > PS_W) ? PS_W : int'(code);
        full = (PS_W+1)'((1 << n) - 1);
        return full[PS_W-1:0];
    endfunction

endpackage

// File: rtl/tcp_ctrl_reg.sv
module tcp_ctrl_reg
    import tcp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output ctrl_t       ctrl,
    output logic [7:0]  rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '{src: SRC_BUS, div: '0};
        end else if (wr_en) begin
            ctrl <= '{src: src_e'(wr_data[5:4]), div: wr_data[3:0]};
        end
    end

    assign rd_data = {2'b00, ctrl};

    assert_reg_update_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data == {2'b00, $past(wr_data[5:0])});

    assert_reg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data));

endmodule

// File: rtl/tcp_src_sel.sv
module tcp_src_sel
    import tcp_pkg::*;
#(
    parameter int SYNC_N = 2
)(
    input  logic clk,
    input  logic rst,
    input  src_e src,
    input  logic fixed_stb,
    input  logic ext_pin,
    output logic event_o
);

    localparam int SH_W = SYNC_N + 1;

    logic [SH_W-1:0] sh;
    logic            pin_now;
    logic            pin_prev;
    logic            rise_ev;
    logic            fall_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[SH_W-2:0], ext_pin};
        end
    end

    assign pin_now  = sh[SYNC_N-1];
    assign pin_prev = sh[SYNC_N];
    assign rise_ev  = pin_now & ~pin_prev;
    assign fall_ev  = ~pin_now & pin_prev;

    always_comb begin
        unique case (src)
            SRC_BUS:      event_o = 1'b1;
            SRC_FIXED:    event_o = fixed_stb;
            SRC_PIN_FALL: event_o = fall_ev;
            SRC_PIN_RISE: event_o = rise_ev;
            default:      event_o = 1'b1;
        endcase
    end

    assert_fixed_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_FIXED && !fixed_stb) |-> !event_o);

    assert_edge_single_R5: assert property (@(posedge clk) disable iff (rst)
        (src inside {SRC_PIN_FALL, SRC_PIN_RISE}) && event_o && $stable(src) |=> !event_o || !$stable(src));

endmodule

// File: rtl/tcp_divider.sv
module tcp_divider
    import tcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              halt,
    input  logic              event_i,
    input  logic [CODE_W-1:0] div,
    output logic              tick
);

    logic [PS_W-1:0] cnt;
    logic [PS_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            cnt <= '0;
        end else if (event_i) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign mask = tap_mask(div);
    assign tick = !halt && event_i && ((cnt & mask) == mask);

    assert_tick_needs_event_R7: assert property (@(posedge clk) disable iff (rst)
        tick |-> event_i);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!halt && !event_i) |=> $stable(cnt));

    assert_halt_clear_R10: assert property (@(posedge clk) disable iff (rst)
        halt |=> cnt == '0);

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        halt |-> !tick);

endmodule

// File: rtl/tmr_cnt_enable.sv
module tmr_cnt_enable
    import tcp_pkg::*;
#(
    parameter int SYNC_N = 2
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       fixed_stb,
    input  logic       ext_pin,
    input  logic       halt,
    output logic       tick
);

    ctrl_t ctrl;
    logic  src_event;

    tcp_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .rd_data (rd_data)
    );

    tcp_src_sel #(.SYNC_N(SYNC_N)) u_src (
        .clk       (clk),
        .rst       (rst),
        .src       (ctrl.src),
        .fixed_stb (fixed_stb),
        .ext_pin   (ext_pin),
        .event_o   (src_event)
    );

    tcp_divider u_div (
        .clk     (clk),
        .rst     (rst),
        .halt    (halt),
        .event_i (src_event),
        .div     (ctrl.div),
        .tick    (tick)
    );

    assert_bus_div1_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_data == 8'h00 && !halt) |-> tick);

endmodule

// File: tb/tmr_cnt_enable_tb_top.sv
`timescale 1ns/1ps
module tmr_cnt_enable_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       fixed_stb = 1'b0;
    logic       ext_pin = 1'b1;
    logic       halt = 1'b1;
    logic       tick;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tmr_cnt_enable dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .fixed_stb(fixed_stb), .ext_pin(ext_pin), .halt(halt), .tick(tick)
    );

    // Vectors: control byte, cycles run from a cleared prescaler, expected ticks.
    localparam int NV = 9;
    localparam logic [7:0] V_CTRL [NV] = '{8'h00, 8'h01, 8'h03, 8'h05, 8'h07, 8'h08, 8'h09, 8'h0F, 8'hC3};
    localparam int         V_CYC  [NV] = '{40, 300, 300, 300, 513, 600, 600, 520, 70};
    localparam int         V_EXP  [NV] = '{40, 150, 37, 9, 4, 2, 2, 2, 8};
    localparam string      V_REQ  [NV] = '{"R3", "R7", "R7", "R7", "R7", "R7", "R8", "R8", "R2"};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            fixed_stb = 1'b1; @(negedge clk);
            fixed_stb = 1'b0; @(negedge clk);
        end
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset value", rd_data, 8'h00);
        check("R10 halt quiet", tick, 0);
        @(negedge clk);
        halt = 1'b0;
        cnt = 0;
        for (int i = 0; i < 10; i++) begin #1; cnt += tick; @(negedge clk); end
        check("R1 bus div1 after reset", cnt, 10);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            halt = 1'b1;
            write_ctrl(V_CTRL[v]);
            #1;
            check("R2 readback", rd_data, {2'b00, V_CTRL[v][5:0]});
            @(negedge clk);
            halt = 1'b0;
            cnt = 0;
            for (int i = 0; i < V_CYC[v]; i++) begin #1; cnt += tick; @(negedge clk); end
            check(V_REQ[v], cnt, V_EXP[v]);
        end

        // R4: fixed strobe gates events
        halt = 1'b1; write_ctrl(8'h10); @(negedge clk); halt = 1'b0;
        for (int i = 0; i < 12; i++) begin
            fixed_stb = (i % 3 == 1);
            #1; check("R4 strobe gating", tick, fixed_stb);
            @(negedge clk);
        end
        fixed_stb = 1'b0;

        // R5: falling edge of pin, source 10
        halt = 1'b1; write_ctrl(8'h20); @(negedge clk); halt = 1'b0;
        repeat (4) @(negedge clk);
        ext_pin = 1'b0;
        cnt = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk); #1;
            if (i == 2) check("R5 fall latency", tick, 1);
            cnt += tick;
        end
        check("R5 single event", cnt, 1);
        ext_pin = 1'b1;
        cnt = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); #1; cnt += tick; end
        check("R5 rise ignored", cnt, 0);

        // R6: rising edge of pin, source 11
        @(negedge clk);
        write_ctrl(8'h30);
        ext_pin = 1'b0;
        repeat (5) @(negedge clk);
        ext_pin = 1'b1;
        cnt = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk); #1;
            if (i == 2) check("R6 rise latency", tick, 1);
            cnt += tick;
        end
        check("R6 single event", cnt, 1);
        ext_pin = 1'b0;
        cnt = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); #1; cnt += tick; end
        check("R6 fall ignored", cnt, 0);
        ext_pin = 1'b1;
        repeat (4) @(negedge clk);

        // R9: source change keeps the count (fixed div4, 2 events, then bus)
        halt = 1'b1; write_ctrl(8'h12); @(negedge clk); halt = 1'b0;
        pulses(2);
        write_ctrl(8'h02);
        #1; check("R9 source change no early tick", tick, 0);
        @(negedge clk); #1;
        check("R9 source change keeps count", tick, 1);
        @(negedge clk);

        // R9: division change keeps the count (fixed div8, 5 events, then div2)
        halt = 1'b1; write_ctrl(8'h13); @(negedge clk); halt = 1'b0;
        pulses(5);
        write_ctrl(8'h11);
        fixed_stb = 1'b1; #1;
        check("R9 division change keeps count", tick, 1);
        @(negedge clk); fixed_stb = 1'b0;

        // R10: halt clears prescaler and silences ticks
        write_ctrl(8'h01);
        halt = 1'b1;
        cnt = 0;
        for (int i = 0; i < 5; i++) begin #1; cnt += tick; @(negedge clk); end
        check("R10 halt silences", cnt, 0);
        halt = 1'b0; #1;
        check("R10 cleared first event", tick, 0);
        @(negedge clk); #1;
        check("R10 cleared second event", tick, 1);

        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule